// File: doc/BRIEF.md
# Bidirectional Latched/Registered Bus Transceiver

This block moves data between two buses, A and B, in both directions at the same time. The data width is a parameter and defaults to 18 bits. Each direction has its own holding register and its own three controls: a gate input, a data strobe and a drive enable. With the gate high, the destination port follows the source port in the same cycle. With the gate low, the destination port shows the held value. That value is reloaded whenever the strobe goes from high to low.

The whole block runs on one system clock. The strobes and gates are ordinary sampled inputs. A strobe falling edge is found by comparing the strobe with its value at the previous system clock edge. Each port that could be tri-stated is modelled as a data vector plus a drive flag. The A-to-B drive enable is active high. The B-to-A drive enable is active low.

Top module: `bidir_hold_xcvr`

## Requirements
- R1: While a direction's gate input is high, its destination output equals its source input in the same cycle, and the holding register reloads from the source at every system clock edge.
- R2: While the gate is low and no strobe falling edge is seen, the destination output keeps its held value, whatever the source data does.
- R3: With the gate low, a falling edge of the strobe (sampled high at one system clock edge and low at the next) loads the source data present at the second of those edges. The new value appears on the destination output after that edge. Each strobe edge causes exactly one load.
- R4: b_drive is 1 exactly when ab_oe is 1 and reset is not asserted.
- R5: a_drive is 1 exactly when ba_oe_n is 0 and reset is not asserted.
- R6: A synchronous active-low reset clears both holding registers to zero and forces a_drive and b_drive to 0 while rst_n is 0.
- R7: The two directions are independent: gate, strobe and data activity in one direction never changes the value held by the other.
- R8: When both drive enables are active together, both ports drive; the overlap is reported as a coverage event and is not suppressed.
- R9: If the gate falls while the strobe is high, the register keeps the data from the last cycle in which the gate was high. The next strobe falling edge with the gate still low then loads new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | WIDTH | Data sensed on the A bus |
| a_out | output | WIDTH | Data presented to the A bus |
| a_drive | output | 1 | A bus is driven when 1 |
| b_in | input | WIDTH | Data sensed on the B bus |
| b_out | output | WIDTH | Data presented to the B bus |
| b_drive | output | 1 | B bus is driven when 1 |
| ab_oe | input | 1 | A-to-B drive enable, active high |
| ab_le | input | 1 | A-to-B gate, transparent when 1 |
| ab_dclk | input | 1 | A-to-B strobe, loads on its falling edge |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A gate, transparent when 1 |
| ba_dclk | input | 1 | B-to-A strobe, loads on its falling edge |

## Verification
The embedded properties check several rules on every cycle. They check the same-cycle transparent path and the hold of the stored value when no strobe edge occurs. They check the load one edge after a detected strobe fall, the polarity of each drive enable, and the reset gating of the drive flags. The bench scenarios are needed for the rest. These cover the gate falling while the strobe is high and the single load per edge. They also cover isolation between the two directions while both are active, and the zero contents seen just after reset is released.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic {
      OE_ACT_HIGH = 1'b0,
      OE_ACT_LOW  = 1'b1
   } oe_pol_e;
endpackage

// File: rtl/xcvr_fall_det.sv
module xcvr_fall_det (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic fall
);
   logic strobe_q;

   always_ff @(posedge clk) begin
      if (!rst_n) strobe_q <= 1'b0;
      else        strobe_q <= strobe;
   end

   assign fall = strobe_q & ~strobe;

   AST_ONE_LOAD_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall);  // R3
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane #(
   parameter int               WIDTH  = 18,
   parameter xcvr_pkg::oe_pol_e OE_POL = xcvr_pkg::OE_ACT_HIGH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate,
   input  logic             strobe,
   input  logic             oe_raw,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             drive
);
   localparam logic [WIDTH-1:0] ZERO = '0;

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("xcvr_lane: WIDTH must be at least 1");
      end
   endgenerate

   logic             fall;
   logic             oe_on;
   logic [WIDTH-1:0] hold_q;

   xcvr_fall_det u_fall (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (strobe),
      .fall   (fall)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)           hold_q <= ZERO;
      else if (gate || fall) hold_q <= din;
   end

   assign dout = gate ? din : hold_q;

   generate
      if (OE_POL == xcvr_pkg::OE_ACT_LOW) begin : g_oe_low
         assign oe_on = ~oe_raw;
      end else begin : g_oe_high
         assign oe_on = oe_raw;
      end
   endgenerate

   assign drive = oe_on & rst_n;

   AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !gate && !$past(gate) && !($past(strobe, 2) && !$past(strobe)))
      |-> dout == $past(dout));  // R2

   AST_EDGE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !gate && $past(strobe) && !strobe)
      |=> (gate || dout == $past(din)));  // R3

   AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(rst_n) && !gate) |-> dout == ZERO);  // R6
endmodule

// File: rtl/bidir_hold_xcvr.sv
module bidir_hold_xcvr #(
   parameter int WIDTH = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] a_in,
   output logic [WIDTH-1:0] a_out,
   output logic             a_drive,
   input  logic [WIDTH-1:0] b_in,
   output logic [WIDTH-1:0] b_out,
   output logic             b_drive,
   input  logic             ab_oe,
   input  logic             ab_le,
   input  logic             ab_dclk,
   input  logic             ba_oe_n,
   input  logic             ba_le,
   input  logic             ba_dclk
);
   generate
      if (WIDTH < 1 || WIDTH > 1024) begin : g_bad_width
         $error("bidir_hold_xcvr: WIDTH out of range 1..1024");
      end
   endgenerate

   xcvr_lane #(.WIDTH(WIDTH), .OE_POL(xcvr_pkg::OE_ACT_HIGH)) u_a2b (
      .clk    (clk),
      .rst_n  (rst_n),
      .gate   (ab_le),
      .strobe (ab_dclk),
      .oe_raw (ab_oe),
      .din    (a_in),
      .dout   (b_out),
      .drive  (b_drive)
   );

   xcvr_lane #(.WIDTH(WIDTH), .OE_POL(xcvr_pkg::OE_ACT_LOW)) u_b2a (
      .clk    (clk),
      .rst_n  (rst_n),
      .gate   (ba_le),
      .strobe (ba_dclk),
      .oe_raw (ba_oe_n),
      .din    (b_in),
      .dout   (a_out),
      .drive  (a_drive)
   );

   AST_A2B_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
      ab_le |-> b_out == a_in);  // R1
   AST_B2A_TRANSPARENT: assert property (@(posedge clk) disable iff (!rst_n)
      ba_le |-> a_out == b_in);  // R1
   AST_A2B_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      b_drive == ab_oe);  // R4
   AST_B2A_OE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      a_drive == !ba_oe_n);  // R5
   AST_RESET_NO_DRIVE: assert property (@(posedge clk)
      !rst_n |-> (!a_drive && !b_drive));  // R6
   AST_BOTH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_oe && !ba_oe_n) |-> (a_drive && b_drive));  // R8
   COV_CONTENTION: cover property (@(posedge clk) disable iff (!rst_n)
      a_drive && b_drive);  // R8
endmodule

// File: tb/bidir_hold_xcvr_tb_top.sv
module bidir_hold_xcvr_tb_top;
   localparam int W = 18;
   localparam int NV = 11;
   localparam int VB = 3 + 2 * W + 1;

   // row: {gate, strobe, oe, a_in, expected b_out, expected b_drive}
   localparam logic [VB-1:0] TBL [0:NV-1] = '{
      {1'b1, 1'b0, 1'b1, 18'h12345, 18'h12345, 1'b1},  // R1 transparent
      {1'b1, 1'b0, 1'b1, 18'h2AAAA, 18'h2AAAA, 1'b1},  // R1 follows new data
      {1'b0, 1'b0, 1'b1, 18'h15555, 18'h2AAAA, 1'b1},  // R2 hold
      {1'b0, 1'b1, 1'b1, 18'h00F0F, 18'h2AAAA, 1'b1},  // R2 rising strobe ignored
      {1'b0, 1'b0, 1'b1, 18'h3C3C3, 18'h3C3C3, 1'b1},  // R3 falling strobe loads
      {1'b0, 1'b0, 1'b1, 18'h11111, 18'h3C3C3, 1'b1},  // R3 single load per edge
      {1'b0, 1'b0, 1'b0, 18'h11111, 18'h3C3C3, 1'b0},  // R4 drive off
      {1'b1, 1'b1, 1'b1, 18'h0ABCD, 18'h0ABCD, 1'b1},  // R1 with strobe high
      {1'b0, 1'b1, 1'b1, 18'h3FFFF, 18'h0ABCD, 1'b1},  // R9 gate falls, strobe high
      {1'b0, 1'b0, 1'b1, 18'h20001, 18'h20001, 1'b1},  // R9 next fall reloads
      {1'b1, 1'b0, 1'b1, 18'h00000, 18'h00000, 1'b1}   // R1 zero data
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic [W-1:0] a_out, b_out;
   logic a_drive, b_drive;
   logic ab_oe = 1'b1, ab_le = 1'b0, ab_dclk = 1'b0;
   logic ba_oe_n = 1'b0, ba_le = 1'b0, ba_dclk = 1'b0;
   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   bidir_hold_xcvr #(.WIDTH(W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
      .b_in(b_in), .b_out(b_out), .b_drive(b_drive),
      .ab_oe(ab_oe), .ab_le(ab_le), .ab_dclk(ab_dclk),
      .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_dclk(ba_dclk)
   );

   task automatic chk(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", tag, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R6: reset with both drive enables active
      repeat (3) tick();
      chk("R6 a_drive in reset", W'(a_drive), W'(0));
      chk("R6 b_drive in reset", W'(b_drive), W'(0));
      @(negedge clk); rst_n = 1'b1;
      tick();
      chk("R6 b_out cleared", b_out, '0);
      chk("R6 a_out cleared", a_out, '0);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         {ab_le, ab_dclk, ab_oe, a_in} = TBL[i][VB-1 -: 3+W];
         tick();
         chk($sformatf("row %0d R1/R2/R3/R4/R9 b_out", i), b_out, TBL[i][W:1]);
         chk($sformatf("row %0d R4 b_drive", i), W'(b_drive), W'(TBL[i][0]));
      end

      // R5 and R1 in the B-to-A direction
      @(negedge clk); ba_oe_n = 1'b0; ba_le = 1'b1; b_in = 18'h0F0F0;
      tick();
      chk("R5 a_drive on when low", W'(a_drive), W'(1));
      chk("R1 a_out transparent", a_out, 18'h0F0F0);
      @(negedge clk); ba_le = 1'b0; b_in = 18'h33333;
      tick();
      chk("R2 a_out held", a_out, 18'h0F0F0);

      // R7: A-to-B activity leaves B-to-A storage alone
      @(negedge clk); ab_le = 1'b0; ab_dclk = 1'b1;
      tick();
      @(negedge clk); ab_dclk = 1'b0; a_in = 18'h05A5A;
      tick();
      chk("R3 b_out loaded", b_out, 18'h05A5A);
      chk("R7 a_out unchanged", a_out, 18'h0F0F0);

      @(negedge clk); ba_oe_n = 1'b1;
      tick();
      chk("R5 a_drive off when high", W'(a_drive), W'(0));

      // R8 both enabled
      @(negedge clk); ab_oe = 1'b1; ba_oe_n = 1'b0;
      tick();
      chk("R8 a_drive", W'(a_drive), W'(1));
      chk("R8 b_drive", W'(b_drive), W'(1));

      // R3 / R7 B-to-A strobe load, A-to-B held
      @(negedge clk); ba_dclk = 1'b1;
      tick();
      @(negedge clk); ba_dclk = 1'b0; b_in = 18'h2468A;
      tick();
      chk("R3 a_out loaded", a_out, 18'h2468A);
      chk("R7 b_out unchanged", b_out, 18'h05A5A);

      // R6 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      tick();
      chk("R6 a_drive mid reset", W'(a_drive), W'(0));
      chk("R6 b_drive mid reset", W'(b_drive), W'(0));
      tick();
      @(negedge clk); rst_n = 1'b1;
      tick();
      chk("R6 b_out zero after reset", b_out, '0);
      chk("R6 a_out zero after reset", a_out, '0);
      chk("R4 b_drive restored", W'(b_drive), W'(1));

      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end
endmodule